// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Core

This block is the per-processor end of an interrupt fabric. It takes in interrupt vectors from the system, each tagged as edge or level triggered. It keeps a 256-entry pending set, a 256-entry in-service set and a 256-entry trigger-type set. It derives a processor priority from a software task priority and the class of the most urgent in-service vector. It raises a single interrupt line toward the processor when a pending request outranks that priority.

The processor has two ways to interact with the block. It pulses an acknowledge input, which returns the vector to service and moves that vector from pending to in-service. It also uses a word-indexed register port, where the index is the byte address shifted right by four. Through this port it programs the task priority and the enable/spurious register, signals end-of-interrupt, and reads back the three vector sets, the processor priority and an error flag.

A small three-state response sequencer sets when each answer appears. The states are ST_IDLE, ST_ACK_OUT and ST_RD_OUT. An acknowledge request moves the sequencer to ST_ACK_OUT. A read with no acknowledge in the same cycle moves it to ST_RD_OUT. Any other cycle returns it to ST_IDLE, and any state can go to any other on the next edge.

Top module: `intr_accept_core`

## Requirements
- R1: An accepted vector (`in_valid` high) sets its pending bit. Its trigger bit is set when `in_level` is 1 (level) and cleared when it is 0 (edge).
- R2: Priority rises with vector number. The priority class of a vector is its bits 7:4. Acknowledge and end-of-interrupt always act on the highest-numbered set bit.
- R3: Processor priority equals the task priority when the task-priority bits 7:4 are at least the class of the highest in-service vector (class 0 when none is in service). Otherwise it equals that class shifted left by 4. It reads at index 0x0A, and writes to 0x0A have no effect.
- R4: `irq_out` is high only when all three conditions hold: enable bit 8 of the spurious register is set, some vector is pending, and either the processor priority is zero or the class of the highest pending vector is greater than processor-priority bits 7:4.
- R5: Acknowledge with the enable set and a pending vector has two outcomes. If the task priority is non-zero and the highest pending vector is numerically at most the task priority, the response is spurious-register bits 7:0 and the pending set is unchanged. Otherwise the highest pending vector is returned and moved to in-service.
- R6: A write to index 0x0B clears the highest in-service bit. With an empty in-service set it changes nothing.
- R7: Register map: task priority at 0x08 (8 bits); spurious/enable at 0x0F, where a write keeps bits 8:0 only; in-service words at 0x10–0x17, trigger words at 0x18–0x1F and pending words at 0x20–0x27, with word w holding vectors 32w..32w+31 and bit 0 being the lowest; error status at 0x28, where bit 7 is the bad-index flag.
- R8: A read or write at any index not listed in R3, R6 or R7 sets error bit 7, which stays set until reset. Such a read returns zero. Index 0x0B counts as undecoded for reads.
- R9: After reset the task priority is 0, the spurious register is 0x0FF (disabled), and the pending, in-service, trigger and error state are all zero.
- R10: With the enable bit clear, `irq_out` stays low. An acknowledge then reports `ack_none` = 1 and leaves all sets unchanged. The same response is given when nothing is pending.
- R11: Writes to the vector-set words (0x10–0x27) and to the error status (0x28) are ignored and do not flag an error.
- R12: Acknowledge and read results appear with their valid strobe exactly one cycle after the request. When an acknowledge and a read arrive in the same cycle, only the acknowledge is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming vector strobe |
| in_vector | input | 8 | Incoming vector number |
| in_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| ack_req | input | 1 | Acknowledge request from the processor |
| ack_valid | output | 1 | Acknowledge response strobe |
| ack_none | output | 1 | Acknowledge found nothing deliverable |
| ack_vector | output | 8 | Returned vector (or spurious vector) |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_addr | input | 12 | Byte address; index is bits 11:4 |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 32 | Read data |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The three vector sets and the priority registers are updated on the edge that samples the request. `irq_out` is a decode of those registers, so it is correct one edge after any accept, acknowledge or register write. The acknowledge and read responses pass through one register stage, so they appear with their strobes on that same edge and drop again on the next. Each bench operation drives inputs after a falling edge and samples all outputs one nanosecond after the rising edge that consumed them. The bench computes expected values from its own model before that edge and updates the model to the state after the edge.

// File: rtl/iac_pkg.sv
package iac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK_OUT = 2'd1,
        ST_RD_OUT  = 2'd2
    } resp_st_t;

    localparam logic [7:0] IX_TPR = 8'h08;
    localparam logic [7:0] IX_PPR = 8'h0A;
    localparam logic [7:0] IX_EOI = 8'h0B;
    localparam logic [7:0] IX_SVR = 8'h0F;
    localparam logic [7:0] IX_ISR = 8'h10;
    localparam logic [7:0] IX_TMR = 8'h18;
    localparam logic [7:0] IX_IRR = 8'h20;
    localparam logic [7:0] IX_ESR = 8'h28;

    localparam int ESR_BADIX_BIT = 7;
    localparam int CLASS_LO      = 4;
endpackage

// File: rtl/iac_prio_enc.sv
module iac_prio_enc #(
    parameter int N  = 256,
    parameter int W  = $clog2(N)
) (
    input  logic [N-1:0] bits,
    output logic         any,
    output logic [W-1:0] top
);
    always_comb begin
        any = |bits;
        top = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) top = W'(i);
        end
    end
endmodule

// File: rtl/iac_prio_calc.sv
module iac_prio_calc #(
    parameter int VW = 8
) (
    input  logic          enable,
    input  logic [VW-1:0] tpr,
    input  logic          irr_any,
    input  logic [VW-1:0] irr_top,
    input  logic          isr_any,
    input  logic [VW-1:0] isr_top,
    output logic [VW-1:0] ppr,
    output logic          irq,
    output logic          spur
);
    import iac_pkg::*;
    localparam int CW = VW - CLASS_LO;

    logic [CW-1:0] isr_cls;

    always_comb begin
        isr_cls = isr_any ? isr_top[VW-1:CLASS_LO] : '0;
        if (tpr[VW-1:CLASS_LO] >= isr_cls) ppr = tpr;
        else                               ppr = {isr_cls, {CLASS_LO{1'b0}}};
        irq  = enable && irr_any &&
               ((ppr == '0) || (irr_top[VW-1:CLASS_LO] > ppr[VW-1:CLASS_LO]));
        spur = (tpr != '0) && (irr_top <= tpr);
    end
endmodule

// File: rtl/iac_vec_bank.sv
module iac_vec_bank #(
    parameter int VW   = 8,
    parameter int NVEC = 1 << VW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_en,
    input  logic [VW-1:0]   acc_vec,
    input  logic            acc_level,
    input  logic            mv_en,
    input  logic [VW-1:0]   mv_vec,
    input  logic            clr_en,
    input  logic [VW-1:0]   clr_vec,
    output logic [NVEC-1:0] irr,
    output logic [NVEC-1:0] isr,
    output logic [NVEC-1:0] tmr
);
    for (genvar b = 0; b < NVEC; b++) begin : g_bit
        logic req_q, svc_q, trg_q;
        logic acc_hit, mv_hit, clr_hit;

        assign acc_hit = acc_en && (acc_vec == VW'(b));
        assign mv_hit  = mv_en  && (mv_vec  == VW'(b));
        assign clr_hit = clr_en && (clr_vec == VW'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q <= 1'b0;
                svc_q <= 1'b0;
                trg_q <= 1'b0;
            end else begin
                if (mv_hit)  req_q <= 1'b0;
                if (acc_hit) begin
                    req_q <= 1'b1;
                    trg_q <= acc_level;
                end
                if (mv_hit)  svc_q <= 1'b1;
                if (clr_hit) svc_q <= 1'b0;
            end
        end

        assign irr[b] = req_q;
        assign isr[b] = svc_q;
        assign tmr[b] = trg_q;
    end
endmodule

// File: rtl/intr_accept_core.sv
module intr_accept_core #(
    parameter int VW = 8,
    parameter int DW = 32,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [VW-1:0] in_vector,
    input  logic          in_level,
    input  logic          ack_req,
    output logic          ack_valid,
    output logic          ack_none,
    output logic [VW-1:0] ack_vector,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          irq_out
);
    import iac_pkg::*;

    localparam int NVEC  = 1 << VW;
    localparam int NWORD = NVEC / DW;
    localparam int WSW   = $clog2(NWORD);
    localparam int IXW   = AW - 4;

    resp_st_t state_q, state_d;

    logic [VW-1:0]   tpr_q;
    logic [VW:0]     svr_q;
    logic            err_q;
    logic [VW-1:0]   ack_vec_q;
    logic            ack_none_q;
    logic [DW-1:0]   rdata_q;

    logic [NVEC-1:0] irr_v, isr_v, tmr_v;
    logic            irr_any, isr_any;
    logic [VW-1:0]   irr_top, isr_top;
    logic [VW-1:0]   ppr;
    logic            irq_w, spur;

    logic [IXW-1:0]  idx;
    logic [WSW-1:0]  wsel;
    logic            hit_tpr, hit_ppr, hit_eoi, hit_svr, hit_esr;
    logic            hit_isr, hit_tmr, hit_irr;
    logic            rd_ok, wr_ok, rd_go;
    logic            mv_en, eoi_en;
    logic [DW-1:0]   rd_val;

    function automatic logic in_rng(input logic [IXW-1:0] i, input logic [7:0] base);
        return (i >= IXW'(base)) && (i < IXW'(base) + IXW'(NWORD));
    endfunction

    assign idx  = reg_addr[AW-1:4];
    assign wsel = idx[WSW-1:0];

    always_comb begin
        hit_tpr = (idx == IXW'(IX_TPR));
        hit_ppr = (idx == IXW'(IX_PPR));
        hit_eoi = (idx == IXW'(IX_EOI));
        hit_svr = (idx == IXW'(IX_SVR));
        hit_esr = (idx == IXW'(IX_ESR));
        hit_isr = in_rng(idx, IX_ISR);
        hit_tmr = in_rng(idx, IX_TMR);
        hit_irr = in_rng(idx, IX_IRR);
        rd_ok   = hit_tpr | hit_ppr | hit_svr | hit_esr | hit_isr | hit_tmr | hit_irr;
        wr_ok   = rd_ok | hit_eoi;
        rd_go   = reg_rd && !ack_req;
    end

    iac_prio_enc #(.N(NVEC), .W(VW)) u_irr_enc (
        .bits (irr_v),
        .any  (irr_any),
        .top  (irr_top)
    );

    iac_prio_enc #(.N(NVEC), .W(VW)) u_isr_enc (
        .bits (isr_v),
        .any  (isr_any),
        .top  (isr_top)
    );

    iac_prio_calc #(.VW(VW)) u_calc (
        .enable  (svr_q[VW]),
        .tpr     (tpr_q),
        .irr_any (irr_any),
        .irr_top (irr_top),
        .isr_any (isr_any),
        .isr_top (isr_top),
        .ppr     (ppr),
        .irq     (irq_w),
        .spur    (spur)
    );

    assign mv_en  = ack_req && svr_q[VW] && irr_any && !spur;
    assign eoi_en = reg_wr && hit_eoi && isr_any;

    iac_vec_bank #(.VW(VW), .NVEC(NVEC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (in_valid),
        .acc_vec   (in_vector),
        .acc_level (in_level),
        .mv_en     (mv_en),
        .mv_vec    (irr_top),
        .clr_en    (eoi_en),
        .clr_vec   (isr_top),
        .irr       (irr_v),
        .isr       (isr_v),
        .tmr       (tmr_v)
    );

    always_comb begin
        rd_val = '0;
        if (hit_tpr)      rd_val = DW'(tpr_q);
        else if (hit_ppr) rd_val = DW'(ppr);
        else if (hit_svr) rd_val = DW'(svr_q);
        else if (hit_isr) rd_val = isr_v[int'(wsel)*DW +: DW];
        else if (hit_tmr) rd_val = tmr_v[int'(wsel)*DW +: DW];
        else if (hit_irr) rd_val = irr_v[int'(wsel)*DW +: DW];
        else if (hit_esr) rd_val = DW'(err_q) << ESR_BADIX_BIT;
    end

    // Next-state logic of the response sequencer
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ACK_OUT, ST_RD_OUT: begin
                if (ack_req)    state_d = ST_ACK_OUT;
                else if (rd_go) state_d = ST_RD_OUT;
                else            state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q      <= '0;
            svr_q      <= {1'b0, {VW{1'b1}}};
            err_q      <= 1'b0;
            ack_vec_q  <= '0;
            ack_none_q <= 1'b0;
            rdata_q    <= '0;
        end else begin
            if (reg_wr && hit_tpr) tpr_q <= reg_wdata[VW-1:0];
            if (reg_wr && hit_svr) svr_q <= reg_wdata[VW:0];
            if ((reg_wr && !wr_ok) || (rd_go && !rd_ok)) err_q <= 1'b1;
            if (ack_req) begin
                ack_none_q <= !(svr_q[VW] && irr_any);
                if (!(svr_q[VW] && irr_any)) ack_vec_q <= '0;
                else if (spur)               ack_vec_q <= svr_q[VW-1:0];
                else                         ack_vec_q <= irr_top;
            end
            if (rd_go) rdata_q <= rd_ok ? rd_val : '0;
        end
    end

    // Output decode of the response sequencer
    always_comb begin
        ack_valid = 1'b0;
        rd_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_ACK_OUT: ack_valid = 1'b1;
            ST_RD_OUT:  rd_valid  = 1'b1;
            default:    ;
        endcase
    end

    assign ack_none   = ack_none_q;
    assign ack_vector = ack_vec_q;
    assign rd_data    = rdata_q;
    assign irq_out    = irq_w;
endmodule

// File: rtl/iac_checker.sv
module iac_checker #(
    parameter int VW   = 8,
    parameter int AW   = 12,
    parameter int NVEC = 1 << VW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [VW-1:0]   in_vector,
    input logic            ack_req,
    input logic            reg_rd,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic            ack_valid,
    input logic            rd_valid,
    input logic            irq_out,
    input logic            enable,
    input logic            err,
    input logic [NVEC-1:0] irr,
    input logic [NVEC-1:0] isr
);
    logic [VW-1:0] last_vec;
    always_ff @(posedge clk) last_vec <= in_vector;

    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (enable && (irr != '0)));

    assert_irq_low_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !irq_out);

    assert_accept_sets_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ack_req) |=> irr[last_vec]);

    assert_eoi_clears_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[AW-1:4] == 8'h0B && (isr != '0) && !ack_req)
        |=> ($countones(isr) == $past($countones(isr)) - 1));

    assert_ack_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> (ack_valid && !rd_valid));

    assert_read_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !ack_req) |=> rd_valid);

    assert_bad_index_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[AW-1:4] < 8'h08) |=> err);
endmodule

bind intr_accept_core iac_checker #(.VW(VW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vector (in_vector),
    .ack_req   (ack_req),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .ack_valid (ack_valid),
    .rd_valid  (rd_valid),
    .irq_out   (irq_out),
    .enable    (svr_q[VW]),
    .err       (err_q),
    .irr       (irr_v),
    .isr       (isr_v)
);

// File: tb/intr_accept_core_bench.sv
module intr_accept_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_vector = '0;
    logic        in_level = 1'b0;
    logic        ack_req = 1'b0;
    logic        ack_valid, ack_none;
    logic [7:0]  ack_vector;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        irq_out;

    intr_accept_core u_intr_accept_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vector(in_vector),
        .in_level(in_level), .ack_req(ack_req), .ack_valid(ack_valid),
        .ack_none(ack_none), .ack_vector(ack_vector), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
    logic [7:0]   m_tpr = '0;
    logic [8:0]   m_svr = 9'h0FF;
    logic         m_err = 1'b0;
    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0]  got_vec;
    logic [31:0] got_rd;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic int top_of(input logic [255:0] b);
        int r = -1;
        for (int i = 0; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] m_ppr();
        int t = top_of(m_isr);
        logic [3:0] c = (t < 0) ? 4'h0 : 4'(t >> 4);
        return (m_tpr[7:4] >= c) ? m_tpr : {c, 4'h0};
    endfunction

    function automatic logic m_irq();
        int h = top_of(m_irr);
        logic [7:0] p = m_ppr();
        if (!m_svr[8] || h < 0) return 1'b0;
        return (p == 8'h00) || (4'(h >> 4) > p[7:4]);
    endfunction

    // {decoded, value} per the register map of R7/R8
    function automatic logic [32:0] m_read(input logic [7:0] ix);
        int w = int'(ix[2:0]) * 32;
        if (ix == 8'h08) return {1'b1, 24'h0, m_tpr};
        if (ix == 8'h0A) return {1'b1, 24'h0, m_ppr()};
        if (ix == 8'h0F) return {1'b1, 23'h0, m_svr};
        if (ix >= 8'h10 && ix <= 8'h17) return {1'b1, m_isr[w +: 32]};
        if (ix >= 8'h18 && ix <= 8'h1F) return {1'b1, m_tmr[w +: 32]};
        if (ix >= 8'h20 && ix <= 8'h27) return {1'b1, m_irr[w +: 32]};
        if (ix == 8'h28) return {1'b1, 24'h0, m_err, 7'h0};
        return 33'h0;
    endfunction

    task automatic edge_wait();
        @(posedge clk);
        #1;
        in_valid = 0; ack_req = 0; reg_rd = 0; reg_wr = 0;
    endtask

    task automatic op_accept(input logic [7:0] v, input logic lvl);
        @(negedge clk);
        in_valid = 1; in_vector = v; in_level = lvl;
        edge_wait();
        m_irr[v] = 1'b1; m_tmr[v] = lvl;
        check("R4 irq after accept", 32'(irq_out), 32'(m_irq()));
    endtask

    task automatic op_ack(input logic with_read);
        int h = top_of(m_irr);
        logic en_none = !(m_svr[8] && h >= 0);
        logic [7:0] ev = 8'h00;
        @(negedge clk);
        ack_req = 1; reg_rd = with_read; reg_addr = 12'h280;
        if (!en_none) begin
            if (m_tpr != 0 && h <= int'(m_tpr)) ev = m_svr[7:0];
            else begin
                ev = 8'(h); m_irr[h] = 1'b0; m_isr[h] = 1'b1;
            end
        end
        edge_wait();
        got_vec = ack_vector;
        check("R12 ack strobe", 32'(ack_valid), 32'h1);
        check("R12 read dropped on ack", 32'(rd_valid), 32'h0);
        check(en_none ? "R10 ack none" : "R5 ack none flag", 32'(ack_none), 32'(en_none));
        if (!en_none) check("R5 ack vector", 32'(ack_vector), 32'(ev));
        check("R4 irq after ack", 32'(irq_out), 32'(m_irq()));
    endtask

    task automatic op_write(input logic [7:0] ix, input logic [31:0] d);
        logic [32:0] r = m_read(ix);
        @(negedge clk);
        reg_wr = 1; reg_addr = {ix, 4'h0}; reg_wdata = d;
        edge_wait();
        if (ix == 8'h08) m_tpr = d[7:0];
        else if (ix == 8'h0F) m_svr = d[8:0];
        else if (ix == 8'h0B) begin
            int t = top_of(m_isr);
            if (t >= 0) m_isr[t] = 1'b0;
        end else if (!r[32]) m_err = 1'b1;
        check("R4 irq after write", 32'(irq_out), 32'(m_irq()));
    endtask

    task automatic op_read(input logic [7:0] ix, input string req);
        logic [32:0] r = m_read(ix);
        @(negedge clk);
        reg_rd = 1; reg_addr = {ix, 4'h0};
        edge_wait();
        got_rd = rd_data;
        if (!r[32]) m_err = 1'b1;
        check("R12 read strobe", 32'(rd_valid), 32'h1);
        check(req, rd_data, r[31:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        // R9 reset state
        check("R9 irq after reset", 32'(irq_out), 32'h0);
        check("R9 no response after reset", 32'({ack_valid, rd_valid}), 32'h0);
        op_read(8'h08, "R9 task priority");
        check("R9 task priority literal", got_rd, 32'h0);
        op_read(8'h0F, "R9 spurious reg");
        check("R9 spurious literal", got_rd, 32'h0FF);
        op_read(8'h28, "R9 error status");
        op_read(8'h20, "R9 pending word");
        // disabled
        op_accept(8'h40, 1'b1);
        check("R10 irq low when disabled", 32'(irq_out), 32'h0);
        op_read(8'h22, "R1 pending word 2");
        check("R1 pending bit literal", got_rd, 32'h1);
        op_read(8'h1A, "R1 trigger word 2");
        op_ack(1'b0);
        op_read(8'h22, "R10 pending kept");
        // enable, masking
        op_write(8'h0F, 32'hFFFF_FFFF);
        op_read(8'h0F, "R7 spurious 9-bit mask");
        check("R7 spurious literal", got_rd, 32'h1FF);
        op_write(8'h0F, 32'h0000_010F);
        check("R4 irq enabled", 32'(irq_out), 32'h1);
        op_ack(1'b0);
        check("R5 returns 0x40", 32'(got_vec), 32'h40);
        op_read(8'h12, "R5 in-service word 2");
        op_read(8'h0A, "R3 ppr from isr");
        check("R3 ppr literal", got_rd, 32'h40);
        op_accept(8'h45, 1'b0);
        check("R4 same class blocked", 32'(irq_out), 32'h0);
        op_read(8'h1A, "R1 edge clears trigger");
        op_accept(8'h51, 1'b1);
        check("R4 higher class raises", 32'(irq_out), 32'h1);
        op_ack(1'b0);
        check("R2 highest first", 32'(got_vec), 32'h51);
        op_write(8'h0B, 32'h0);
        op_read(8'h12, "R6 eoi clears highest");
        check("R6 literal", got_rd, 32'h1);
        op_write(8'h08, 32'h60);
        op_read(8'h0A, "R3 ppr from tpr");
        op_ack(1'b0);
        check("R5 spurious vector", 32'(got_vec), 32'h0F);
        op_read(8'h22, "R5 pending unchanged");
        op_write(8'h08, 32'h30);
        op_read(8'h0A, "R3 isr class beats tpr");
        op_write(8'h0B, 32'h0);
        op_write(8'h0B, 32'h0);
        op_read(8'h12, "R6 eoi on empty");
        op_write(8'h08, 32'h45);
        op_ack(1'b0);
        check("R5 equal to tpr is spurious", 32'(got_vec), 32'h0F);
        op_write(8'h08, 32'h44);
        op_ack(1'b0);
        check("R5 above tpr delivered", 32'(got_vec), 32'h45);
        // map corners
        op_write(8'h20, 32'hFFFF_FFFF);
        op_write(8'h0A, 32'hFF);
        op_write(8'h28, 32'hFF);
        op_read(8'h20, "R11 pending write ignored");
        op_read(8'h28, "R11 no error from ignored writes");
        op_read(8'h0A, "R3 ppr write ignored");
        op_read(8'h05, "R8 undecoded read zero");
        op_read(8'h28, "R8 error bit set");
        check("R8 error literal", got_rd, 32'h80);
        op_accept(8'h90, 1'b0);
        op_ack(1'b1);
        // random phase
        for (int n = 0; n < 600; n++) begin
            int sel = int'($urandom % 12);
            if (sel < 4) op_accept(8'($urandom), 1'($urandom));
            else if (sel < 6) op_ack(1'($urandom % 4 == 0));
            else if (sel == 6) op_write(8'h0B, 32'h0);
            else if (sel == 7) op_write(8'h08, 32'($urandom % 256));
            else if (sel == 8) op_read(8'(8'h10 + $urandom % 24), "R7 random vector word");
            else if (sel == 9) op_read(8'h0A, "R3 random ppr");
            else if (sel == 10) op_write(8'h0F, (($urandom % 8) == 0) ? 32'h0EF : 32'h1EF);
            else op_read(8'($urandom % 64), "R8 random index");
        end
        finish_run();
    end
endmodule